// File: doc/BRIEF.md
# Self-Correcting Twisted-Ring Counter with State Decoder

This block is a Johnson (twisted-ring) counter of `N` stages. On every enabled clock edge the register shifts one place toward its top stage, and the inverted top stage is fed back into stage 0. Starting from all zeros, the counter walks a Gray-coded ring of `2*N` states. For the default `N = 3`, the ring is 000, 001, 011, 111, 110, 100 and then back to 000. Each ring state also drives a one-hot strobe. Each strobe is decoded from only two adjacent stage bits, so no strobe can spike while the counter moves from one state to the next.

With `N` stages there are `2^N - 2*N` register values that are not on the ring. If the register ever holds one of them, the block sees it at once. On the next enabled edge it forces the register back to all zeros and raises a flag for one cycle. A test load port can write any value into the register. This lets the recovery logic be exercised from outside the block.

Top module: `johnson_counter`

## Requirements
- R1: While `rst_ni` is low, `stage_o` is all zeros, `state_o` equals 1 (bit 0 set) and `illegal_o` is low.
- R2: On a rising edge with `en_i` high, `load_i` low and a legal value in the register, the new value of `stage_o` is `{stage_o[N-2:0], ~stage_o[N-1]}`.
- R3: On a rising edge with `en_i` and `load_i` both low, `stage_o` keeps its value.
- R4: Starting from all zeros, after `2*N` enabled edges the register is back at all zeros, and no earlier edge in that run reaches all zeros.
- R5: Two consecutive legal states differ in exactly one bit.
- R6: Ring index k (k edges after all zeros) is shown on `state_o[k]`. The decoding is as follows:
  - index 0 is `~q[N-1] & ~q[0]`;
  - index N is `q[N-1] & q[0]`;
  - index k with 0 < k < N is `q[k-1] & ~q[k]`;
  - index N+j with 0 < j < N is `~q[j-1] & q[j]`.
- R7: While the register holds a legal value, exactly one bit of `state_o` is high.
- R8: A value is legal when at most one adjacent pair of its bits differs. While the register holds an illegal value, `state_o` is all zeros.
- R9: An enabled edge with `load_i` low and an illegal value in the register sets `stage_o` to all zeros. The same edge makes `illegal_o` high for the following cycle.
- R10: `illegal_o` is low after every edge other than the one described in R9.
- R11: An edge with `load_i` high loads `load_val_i` into the register, whatever `en_i` is, and leaves `illegal_o` low.
- R12: An illegal value is kept while `en_i` is low, and `illegal_o` stays low during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Count enable |
| load_i | input | 1 | Test load strobe, takes priority over `en_i` |
| load_val_i | input | N | Value written by the test load |
| stage_o | output | N | Raw register stages |
| state_o | output | 2*N | One-hot decoded ring state |
| illegal_o | output | 1 | One-cycle pulse after recovery from an illegal value |

## Verification
A corrupted register value is visible at the ports straight away. While the value is illegal, every decoded strobe is low. One enabled edge later, `stage_o` reads zero and `illegal_o` pulses. A wrong feedback tap or shift direction makes `stage_o` leave the expected ring on the first enabled edge, and the one-hot strobe moves to the wrong index in that same cycle. Illegal values are written through the load port, both with the enable held low and with it high, so that both holding and recovery are observed.

// File: rtl/johnson_pkg.sv
package johnson_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD    = 2'd0,
    ACT_SHIFT   = 2'd1,
    ACT_RECOVER = 2'd2,
    ACT_LOAD    = 2'd3
  } act_e;
endpackage

// File: rtl/johnson_legal.sv
module johnson_legal #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] stage_i,
  output logic         legal_o
);
  localparam logic [N-2:0] ONE = (N-1)'(1);
  logic [N-2:0] edges;

  // a ring value has at most one boundary between its runs of ones and zeros
  assign edges   = stage_i[N-2:0] ^ stage_i[N-1:1];
  assign legal_o = ((edges & (edges - ONE)) == '0);
endmodule

// File: rtl/johnson_step.sv
module johnson_step
  import johnson_pkg::*;
#(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] stage_i,
  input  logic         legal_i,
  input  logic         en_i,
  input  logic         load_i,
  input  logic [N-1:0] load_val_i,
  output act_e         act_o,
  output logic [N-1:0] next_o
);
  always_comb begin
    if (load_i)        act_o = ACT_LOAD;
    else if (!en_i)    act_o = ACT_HOLD;
    else if (!legal_i) act_o = ACT_RECOVER;
    else               act_o = ACT_SHIFT;
  end

  always_comb begin
    unique case (act_o)
      ACT_LOAD:    next_o = load_val_i;
      ACT_SHIFT:   next_o = {stage_i[N-2:0], ~stage_i[N-1]};
      ACT_RECOVER: next_o = '0;
      default:     next_o = stage_i;
    endcase
  end
endmodule

// File: rtl/johnson_decode.sv
module johnson_decode #(
  parameter int unsigned N = 3,
  localparam int unsigned S = 2 * N
) (
  input  logic [N-1:0] stage_i,
  input  logic         legal_i,
  output logic [S-1:0] state_o
);
  logic [S-1:0] raw;

  for (genvar k = 0; k < S; k++) begin : g_dec
    if (k == 0) begin : g_zero
      assign raw[k] = ~stage_i[N-1] & ~stage_i[0];
    end else if (k == N) begin : g_full
      assign raw[k] = stage_i[N-1] & stage_i[0];
    end else if (k < N) begin : g_fill
      assign raw[k] = stage_i[k-1] & ~stage_i[k];
    end else begin : g_drain
      assign raw[k] = ~stage_i[k-N-1] & stage_i[k-N];
    end
  end

  // pair decodes alias on illegal values; blank them
  assign state_o = legal_i ? raw : '0;
endmodule

// File: rtl/johnson_counter.sv
module johnson_counter
  import johnson_pkg::*;
#(
  parameter int unsigned N = 3,
  localparam int unsigned S = 2 * N
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         load_i,
  input  logic [N-1:0] load_val_i,
  output logic [N-1:0] stage_o,
  output logic [S-1:0] state_o,
  output logic         illegal_o
);
  logic [N-1:0] stage_q, stage_d;
  logic         legal;
  logic         illegal_q;
  act_e         act;

  johnson_legal #(.N(N)) u_legal (
    .stage_i (stage_q),
    .legal_o (legal)
  );

  johnson_step #(.N(N)) u_step (
    .stage_i    (stage_q),
    .legal_i    (legal),
    .en_i       (en_i),
    .load_i     (load_i),
    .load_val_i (load_val_i),
    .act_o      (act),
    .next_o     (stage_d)
  );

  johnson_decode #(.N(N)) u_decode (
    .stage_i (stage_q),
    .legal_i (legal),
    .state_o (state_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q   <= '0;
      illegal_q <= 1'b0;
    end else begin
      if (act != ACT_HOLD) stage_q <= stage_d;
      illegal_q <= (act == ACT_RECOVER);
    end
  end

  assign stage_o   = stage_q;
  assign illegal_o = illegal_q;
endmodule

// File: rtl/johnson_counter_sva.sv
module johnson_counter_sva #(
  parameter int unsigned N = 3,
  localparam int unsigned S = 2 * N
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         en_i,
  input logic         load_i,
  input logic [N-1:0] load_val_i,
  input logic [N-1:0] stage_o,
  input logic [S-1:0] state_o,
  input logic         illegal_o
);
  logic ok;
  assign ok = ($countones(stage_o[N-2:0] ^ stage_o[N-1:1]) <= 1);

  always_comb begin
    if (!rst_ni) a_r1_reset: assert (stage_o == '0 && !illegal_o);
  end

  a_r2_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !load_i && ok |=> stage_o == {$past(stage_o[N-2:0]), ~$past(stage_o[N-1])});

  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !load_i |=> $stable(stage_o));

  a_r5_gray: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !load_i && ok |=> $countones(stage_o ^ $past(stage_o)) == 1);

  a_r7_one_hot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok |-> $countones(state_o) == 1);

  a_r8_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ok |-> state_o == '0);

  a_r9_recover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !load_i && !ok |=> stage_o == '0 && illegal_o);

  a_r10_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && !load_i && !ok) |=> !illegal_o);

  a_r11_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> stage_o == $past(load_val_i));
endmodule

bind johnson_counter johnson_counter_sva #(.N(N)) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .load_i     (load_i),
  .load_val_i (load_val_i),
  .stage_o    (stage_o),
  .state_o    (state_o),
  .illegal_o  (illegal_o)
);

// File: tb/johnson_counter_test.sv
module johnson_counter_test;
  localparam int N = 3;
  localparam int S = 2 * N;

  typedef struct {
    logic [N-1:0] stage;
    logic         flag;
    logic [N-1:0] prev;
    logic         gray;
    string        tag;
  } item_t;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         en_i = 1'b0;
  logic         load_i = 1'b0;
  logic [N-1:0] load_val_i = '0;
  logic [N-1:0] stage_o;
  logic [S-1:0] state_o;
  logic         illegal_o;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] model = '0;
  item_t q[$];

  always #5 clk_i = ~clk_i;

  johnson_counter #(.N(N)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .load_i(load_i),
    .load_val_i(load_val_i), .stage_o(stage_o), .state_o(state_o),
    .illegal_o(illegal_o)
  );

  function automatic logic [N-1:0] ring_at(int k);
    logic [N-1:0] s = '0;
    for (int i = 0; i < k; i++) s = {s[N-2:0], ~s[N-1]};
    return s;
  endfunction

  function automatic int ring_idx(logic [N-1:0] v);
    for (int k = 0; k < S; k++) if (ring_at(k) == v) return k;
    return -1;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(logic en, logic ld, logic [N-1:0] val, string tag);
    item_t it;
    @(negedge clk_i);
    en_i = en; load_i = ld; load_val_i = val;
    it.prev = model;
    it.flag = 1'b0;
    it.gray = 1'b0;
    if (ld) model = val;
    else if (en && ring_idx(model) < 0) begin model = '0; it.flag = 1'b1; end
    else if (en) begin model = ring_at((ring_idx(model) + 1) % S); it.gray = 1'b1; end
    it.stage = model;
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (q.size() > 0) begin
        item_t it;
        logic [S-1:0] exp_state;
        int idx;
        it = q.pop_front();
        idx = ring_idx(it.stage);
        exp_state = (idx < 0) ? '0 : (S'(1) << idx);
        check(stage_o == it.stage, it.tag, "stage", int'(stage_o), int'(it.stage));
        check(state_o == exp_state, idx < 0 ? "R8" : "R6", "state", int'(state_o), int'(exp_state));
        check(illegal_o == it.flag, it.flag ? "R9" : "R10", "flag", int'(illegal_o), int'(it.flag));
        if (idx >= 0) check($countones(state_o) == 1, "R7", "onehot", $countones(state_o), 1);
        if (it.gray) check($countones(stage_o ^ it.prev) == 1, "R5", "gray", int'(stage_o ^ it.prev), 0);
      end
    end
  end

  initial begin : watchdog
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(stage_o == '0, "R1", "reset stage", int'(stage_o), 0);
    check(state_o == S'(1), "R1", "reset state", int'(state_o), 1);
    check(illegal_o == 1'b0, "R1", "reset flag", int'(illegal_o), 0);
    rst_ni = 1'b1;
    // three full periods; R4 return to zero only at multiples of 2N
    for (int i = 1; i <= 3 * S; i++) begin
      step(1'b1, 1'b0, '0, "R2");
      @(posedge clk_i); #3;
      check((stage_o == '0) == (i % S == 0), "R4", "period", int'(stage_o), int'(i % S));
    end
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, '0, "R3");
    step(1'b1, 1'b0, '0, "R2");
    step(1'b0, 1'b0, '0, "R3");
    step(1'b1, 1'b0, '0, "R2");
    // illegal 010: hold with enable low, then recover
    step(1'b0, 1'b1, 3'b010, "R11");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, '0, "R12");
    step(1'b1, 1'b0, '0, "R9");
    step(1'b1, 1'b0, '0, "R2");
    // illegal 101 with enable high during load
    step(1'b1, 1'b1, 3'b101, "R11");
    step(1'b1, 1'b0, '0, "R9");
    step(1'b0, 1'b0, '0, "R3");
    // legal mid-ring load, then keep counting
    step(1'b0, 1'b1, 3'b110, "R11");
    for (int i = 0; i < S; i++) step(1'b1, 1'b0, '0, "R2");
    step(1'b1, 1'b1, 3'b010, "R11");
    step(1'b1, 1'b1, 3'b101, "R11");
    step(1'b1, 1'b0, '0, "R9");
    step(1'b0, 1'b0, '0, "R3");
    repeat (3) @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule